// File: doc/BRIEF.md
# Raster-Op Transparency Pixel Unit

This unit is the per-pixel arithmetic stage of a block-transfer drawing engine. For each pixel it receives a source value and the destination value that was read from display memory. The source value is either a colour pixel, the fixed foreground colour, or a single monochrome bit that picks the foreground or the background colour. The unit combines source and destination with one of sixteen two-operand logic functions. It then decides whether the pixel may be written at all, using a colour-key test on the destination and monochrome transparency. Finally it merges the result with the destination under a per-bit write mask. The output is the byte to store and a write enable.

Pixels arrive on a valid/ready stream with 8-bit values. The configuration inputs are captured together with each accepted pixel, so the configuration may change from one pixel to the next. Results leave through a second valid/ready stream, in the same order, after two register stages. Full backpressure is supported. Address generation, memory sequencing and host transfers are handled elsewhere in the engine.

Top module: `rop_pixel_unit`

## Requirements
- R1: While reset is high and after its release, `out_valid` is low until a pixel has been accepted.
- R2: `cfg_rop` selects the logic function of source S and destination D, applied bitwise: 0 all zeros, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), 10 ~D, 11 S|~D, 12 ~S, 13 ~S|D, 14 ~(S&D), 15 all ones.
- R3: `cfg_src_fmt` picks S: 0 (and 3) uses `in_src`; 1 uses `cfg_fg`; 2 uses `cfg_fg` when `in_mono` is 1 and `cfg_bg` when it is 0.
- R4: With `cfg_key_en`=1 and `cfg_key_pol`=0, a destination equal to `cfg_key` is protected: `out_we`=0 and `out_data` equals the destination.
- R5: Each set bit of `cfg_key_mask` excludes that bit from the key comparison.
- R6: With `cfg_key_en`=1 and `cfg_key_pol`=1, the polarity is inverted: only destinations that match the key are written, and non-matching ones are protected (`out_we`=0, data = destination).
- R7: With `cfg_src_fmt`=2 and `cfg_mono_trans`=1, a monochrome 0 protects the pixel (`out_we`=0, data = destination). With `cfg_mono_trans`=0, the background colour is used instead.
- R8: A written pixel takes the ROP result in bits where `cfg_wmask` is 1 and keeps the destination bit where it is 0.
- R9: Results appear in acceptance order, one per accepted pixel. While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_we` hold.
- R10: With `out_ready` held high, one pixel is accepted every cycle, and its result is visible two clock edges after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rop | input | 4 | Logic function code |
| cfg_src_fmt | input | 2 | Source format select |
| cfg_fg | input | 8 | Foreground colour |
| cfg_bg | input | 8 | Background colour |
| cfg_key | input | 8 | Colour key compared with the destination |
| cfg_key_mask | input | 8 | Key bits to ignore (1 = ignore) |
| cfg_key_en | input | 1 | Colour-key protection enable |
| cfg_key_pol | input | 1 | 0 protects matches, 1 protects non-matches |
| cfg_mono_trans | input | 1 | Monochrome zero bits are protected |
| cfg_wmask | input | 8 | Per-bit write mask |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when valid |
| in_src | input | 8 | Source colour pixel |
| in_mono | input | 1 | Monochrome source bit |
| in_dst | input | 8 | Destination pixel read from memory |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts result |
| out_data | output | 8 | Byte to write back |
| out_we | output | 1 | Write enable for this pixel |

## Verification
There are two ways a corrupted stage register shows up at the ports. A wrong captured configuration or a wrong skip flag produces a wrong byte or write enable on the very pixel concerned, two edges after acceptance. A broken valid or ready state shows as a lost, duplicated or reordered result, or as a result that changes during a stall. The scoreboard catches these at the next output handshake. Random stalls exercise the hold path, and a stretch with `out_ready` held high checks the exact two-edge latency and the one-per-cycle acceptance rate.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [1:0] {
    SRC_COLOR = 2'd0,
    SRC_FIXED = 2'd1,
    SRC_MONO  = 2'd2,
    SRC_RSVD  = 2'd3
  } src_fmt_e;

  // one bit of the two-operand logic function
  function automatic logic rop_bit(input logic [3:0] code, input logic s, input logic d);
    logic r;
    case (code)
      4'd0:    r = 1'b0;
      4'd1:    r = s & d;
      4'd2:    r = s & ~d;
      4'd3:    r = s;
      4'd4:    r = ~s & d;
      4'd5:    r = d;
      4'd6:    r = s ^ d;
      4'd7:    r = s | d;
      4'd8:    r = ~(s | d);
      4'd9:    r = ~(s ^ d);
      4'd10:   r = ~d;
      4'd11:   r = s | ~d;
      4'd12:   r = ~s;
      4'd13:   r = ~s | d;
      4'd14:   r = ~(s & d);
      default: r = 1'b1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/rop_src_stage.sv
module rop_src_stage
  import rop_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       cfg_rop,
  input  logic [1:0]       cfg_src_fmt,
  input  logic [PIX_W-1:0] cfg_fg,
  input  logic [PIX_W-1:0] cfg_bg,
  input  logic [PIX_W-1:0] cfg_key,
  input  logic [PIX_W-1:0] cfg_key_mask,
  input  logic             cfg_key_en,
  input  logic             cfg_key_pol,
  input  logic             cfg_mono_trans,
  input  logic [PIX_W-1:0] cfg_wmask,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_src,
  input  logic             in_mono,
  input  logic [PIX_W-1:0] in_dst,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic [PIX_W-1:0] dn_src,
  output logic [PIX_W-1:0] dn_dst,
  output logic             dn_skip,
  output logic [3:0]       dn_rop,
  output logic [PIX_W-1:0] dn_wmask
);
  src_fmt_e         fmt;
  logic [PIX_W-1:0] src_sel;
  logic             key_hit;
  logic             key_block;
  logic             mono_block;
  logic             take;

  assign fmt = src_fmt_e'(cfg_src_fmt);

  always_comb begin
    case (fmt)
      SRC_FIXED: src_sel = cfg_fg;
      SRC_MONO:  src_sel = in_mono ? cfg_fg : cfg_bg;
      default:   src_sel = in_src;
    endcase
  end

  assign key_hit    = ((in_dst ^ cfg_key) & ~cfg_key_mask) == '0;
  assign key_block  = cfg_key_en & (key_hit ^ cfg_key_pol);
  assign mono_block = (fmt == SRC_MONO) & cfg_mono_trans & ~in_mono;

  assign in_ready = ~dn_valid | dn_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) dn_valid <= 1'b0;
    else if (in_ready) dn_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      dn_src   <= src_sel;
      dn_dst   <= in_dst;
      dn_skip  <= key_block | mono_block;
      dn_rop   <= cfg_rop;
      dn_wmask <= cfg_wmask;
    end
  end

  // R10: an empty stage never refuses a pixel
  assert_accept_empty_R10: assert property (@(posedge clk) disable iff (rst)
    !dn_valid |-> in_ready);

  // R9: a stalled stage keeps its contents
  assert_stage_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_dst) && $stable(dn_skip)));
endmodule

// File: rtl/rop_out_stage.sv
module rop_out_stage
  import rop_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic [PIX_W-1:0] up_src,
  input  logic [PIX_W-1:0] up_dst,
  input  logic             up_skip,
  input  logic [3:0]       up_rop,
  input  logic [PIX_W-1:0] up_wmask,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_we
);
  logic [PIX_W-1:0] rop_res;
  logic [PIX_W-1:0] merged;
  logic             take;

  for (genvar b = 0; b < PIX_W; b++) begin : g_bit
    assign rop_res[b] = rop_bit(up_rop, up_src[b], up_dst[b]);
  end

  assign merged   = (rop_res & up_wmask) | (up_dst & ~up_wmask);
  assign up_ready = ~out_valid | out_ready;
  assign take     = up_valid & up_ready;

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else if (up_ready) out_valid <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_data <= up_skip ? up_dst : merged;
      out_we   <= ~up_skip;
    end
  end

  // R4 R6 R7: a protected pixel carries its destination unchanged and no write
  assert_protect_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && take && up_skip) |-> (!out_we && out_data == $past(up_dst)));

  // R8: bits outside the write mask keep the destination
  assert_mask_keep_R8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && take) |-> (((out_data ^ $past(up_dst)) & ~$past(up_wmask)) == '0));

  // R2: code 0 yields zero in every writable bit
  assert_zero_code_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && take && !up_skip && up_rop == 4'd0) |-> ((out_data & $past(up_wmask)) == '0));

  // R9: stalled output holds
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_we)));
endmodule

// File: rtl/rop_pixel_unit.sv
module rop_pixel_unit
  import rop_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       cfg_rop,
  input  logic [1:0]       cfg_src_fmt,
  input  logic [PIX_W-1:0] cfg_fg,
  input  logic [PIX_W-1:0] cfg_bg,
  input  logic [PIX_W-1:0] cfg_key,
  input  logic [PIX_W-1:0] cfg_key_mask,
  input  logic             cfg_key_en,
  input  logic             cfg_key_pol,
  input  logic             cfg_mono_trans,
  input  logic [PIX_W-1:0] cfg_wmask,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_src,
  input  logic             in_mono,
  input  logic [PIX_W-1:0] in_dst,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_we
);
  logic             s1_valid;
  logic             s1_ready;
  logic [PIX_W-1:0] s1_src;
  logic [PIX_W-1:0] s1_dst;
  logic             s1_skip;
  logic [3:0]       s1_rop;
  logic [PIX_W-1:0] s1_wmask;

  rop_src_stage #(.PIX_W(PIX_W)) u_src (
    .clk(clk), .rst(rst),
    .cfg_rop(cfg_rop), .cfg_src_fmt(cfg_src_fmt),
    .cfg_fg(cfg_fg), .cfg_bg(cfg_bg),
    .cfg_key(cfg_key), .cfg_key_mask(cfg_key_mask),
    .cfg_key_en(cfg_key_en), .cfg_key_pol(cfg_key_pol),
    .cfg_mono_trans(cfg_mono_trans), .cfg_wmask(cfg_wmask),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_mono(in_mono), .in_dst(in_dst),
    .dn_valid(s1_valid), .dn_ready(s1_ready),
    .dn_src(s1_src), .dn_dst(s1_dst), .dn_skip(s1_skip),
    .dn_rop(s1_rop), .dn_wmask(s1_wmask)
  );

  rop_out_stage #(.PIX_W(PIX_W)) u_out (
    .clk(clk), .rst(rst),
    .up_valid(s1_valid), .up_ready(s1_ready),
    .up_src(s1_src), .up_dst(s1_dst), .up_skip(s1_skip),
    .up_rop(s1_rop), .up_wmask(s1_wmask),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_we(out_we)
  );

  // R1: nothing emerges right after reset
  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/tb_rop_pixel_unit.sv
module tb_rop_pixel_unit;
  localparam int CLK_PERIOD = 10;
  localparam int QN = 1024;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] cfg_rop = '0;
  logic [1:0] cfg_src_fmt = '0;
  logic [7:0] cfg_fg = '0, cfg_bg = '0, cfg_key = '0, cfg_key_mask = '0, cfg_wmask = 8'hFF;
  logic       cfg_key_en = 1'b0, cfg_key_pol = 1'b0, cfg_mono_trans = 1'b0;
  logic       in_valid = 1'b0, in_mono = 1'b0, out_ready = 1'b0;
  logic [7:0] in_src = '0, in_dst = '0;
  logic       in_ready, out_valid, out_we;
  logic [7:0] out_data;

  // pending configuration, applied at the negedge of each send
  logic [3:0] p_rop = '0;
  logic [1:0] p_fmt = '0;
  logic [7:0] p_fg = '0, p_bg = '0, p_key = '0, p_kmask = '0, p_wmask = 8'hFF;
  logic       p_ken = 1'b0, p_kpol = 1'b0, p_mtr = 1'b0;

  int    total = 0, bad = 0, step_n = 0, wr_ptr = 0, rd_ptr = 0;
  bit    lat_mode = 1'b0;
  logic [7:0] q_data [QN];
  logic       q_we   [QN];
  string      q_tag  [QN];
  int         q_step [QN];

  rop_pixel_unit dut (
    .clk(clk), .rst(rst), .cfg_rop(cfg_rop), .cfg_src_fmt(cfg_src_fmt),
    .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_key(cfg_key), .cfg_key_mask(cfg_key_mask),
    .cfg_key_en(cfg_key_en), .cfg_key_pol(cfg_key_pol), .cfg_mono_trans(cfg_mono_trans),
    .cfg_wmask(cfg_wmask), .in_valid(in_valid), .in_ready(in_ready), .in_src(in_src),
    .in_mono(in_mono), .in_dst(in_dst), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_we(out_we)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_rop(input logic [3:0] c, input logic [7:0] s, input logic [7:0] d);
    case (c)
      4'd0: return 8'h00;        4'd1: return s & d;
      4'd2: return s & ~d;       4'd3: return s;
      4'd4: return ~s & d;       4'd5: return d;
      4'd6: return s ^ d;        4'd7: return s | d;
      4'd8: return ~(s | d);     4'd9: return ~(s ^ d);
      4'd10: return ~d;          4'd11: return s | ~d;
      4'd12: return ~s;          4'd13: return ~s | d;
      4'd14: return ~(s & d);    default: return 8'hFF;
    endcase
  endfunction

  // returns {we, data}
  function automatic logic [8:0] ref_pix();
    logic [7:0] s, r;
    logic protect;
    s = (cfg_src_fmt == 2'd1) ? cfg_fg :
        (cfg_src_fmt == 2'd2) ? (in_mono ? cfg_fg : cfg_bg) : in_src;
    protect = 1'b0;
    if (cfg_key_en) begin
      if ((((in_dst ^ cfg_key) & ~cfg_key_mask) == 8'h00) != cfg_key_pol) protect = 1'b1;
    end
    if (cfg_src_fmt == 2'd2 && cfg_mono_trans && !in_mono) protect = 1'b1;
    r = ref_rop(cfg_rop, s, in_dst);
    if (protect) return {1'b0, in_dst};
    return {1'b1, (r & cfg_wmask) | (in_dst & ~cfg_wmask)};
  endfunction

  task automatic check(input string tag, input bit ok, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual we/data=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called 1 time unit after a negedge; handles both handshakes of the coming edge
  task automatic observe(output bit fired);
    logic [8:0] e;
    #1;
    if (out_valid && out_ready) begin
      if (rd_ptr >= wr_ptr) check("R9 extra result", 1'b0, {out_we, out_data}, 9'h0);
      else begin
        check(q_tag[rd_ptr % QN], {out_we, out_data} == {q_we[rd_ptr % QN], q_data[rd_ptr % QN]},
              {out_we, out_data}, {q_we[rd_ptr % QN], q_data[rd_ptr % QN]});
        if (lat_mode)
          check("R10 latency", (step_n - q_step[rd_ptr % QN]) == 2,
                9'(step_n - q_step[rd_ptr % QN]), 9'd2);
        rd_ptr++;
      end
    end
    fired = in_valid && in_ready;
    if (fired) begin
      e = ref_pix();
      q_we[wr_ptr % QN]   = e[8];
      q_data[wr_ptr % QN] = e[7:0];
      q_step[wr_ptr % QN] = step_n;
      wr_ptr++;
    end
    step_n++;
  endtask

  task automatic send(input string tag, input logic [7:0] s, input logic m, input logic [7:0] d);
    bit fired;
    @(negedge clk);
    cfg_rop = p_rop; cfg_src_fmt = p_fmt; cfg_fg = p_fg; cfg_bg = p_bg;
    cfg_key = p_key; cfg_key_mask = p_kmask; cfg_wmask = p_wmask;
    cfg_key_en = p_ken; cfg_key_pol = p_kpol; cfg_mono_trans = p_mtr;
    in_src = s; in_mono = m; in_dst = d; in_valid = 1'b1;
    q_tag[wr_ptr % QN] = tag;
    out_ready = lat_mode ? 1'b1 : (($urandom % 4) != 0);
    observe(fired);
    if (lat_mode) check("R10 accept each cycle", fired, {8'h0, fired}, 9'h1);
    while (!fired) begin
      @(negedge clk);
      out_ready = (($urandom % 4) != 0);
      observe(fired);
    end
  endtask

  task automatic drain();
    bit fired;
    int n = 0;
    @(negedge clk);
    in_valid = 1'b0;
    while (rd_ptr < wr_ptr && n < 50) begin
      out_ready = 1'b1;
      observe(fired);
      @(negedge clk);
      n++;
    end
    check("R9 all results delivered", rd_ptr == wr_ptr, 9'(rd_ptr), 9'(wr_ptr));
  endtask

  task automatic clear_cfg();
    p_rop = 4'd3; p_fmt = 2'd0; p_fg = 8'h00; p_bg = 8'h00; p_key = 8'h00;
    p_kmask = 8'h00; p_wmask = 8'hFF; p_ken = 1'b0; p_kpol = 1'b0; p_mtr = 1'b0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        bad++; total++;
        $display("FAIL watchdog: actual cycles=%0d expected<=100000", wd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check("R1 reset", out_valid == 1'b0, {8'h0, out_valid}, 9'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", out_valid == 1'b0, {8'h0, out_valid}, 9'h0);

    // R2: every code
    clear_cfg();
    for (int c = 0; c < 16; c++) begin
      p_rop = 4'(c);
      send("R2 rop code", 8'hCA, 1'b0, 8'hAC);
    end
    // R3: source formats
    clear_cfg(); p_fg = 8'h5A; p_bg = 8'h81;
    p_fmt = 2'd0; send("R3 colour src", 8'h33, 1'b0, 8'h00);
    p_fmt = 2'd1; send("R3 fixed fg", 8'h33, 1'b0, 8'h00);
    p_fmt = 2'd2; send("R3 mono one", 8'h33, 1'b1, 8'h00);
    p_fmt = 2'd2; send("R3 mono zero bg", 8'h33, 1'b0, 8'h00);
    // R4: key match protected
    clear_cfg(); p_ken = 1'b1; p_key = 8'h77;
    send("R4 key hit protect", 8'hFF, 1'b0, 8'h77);
    send("R4 key miss write", 8'hFF, 1'b0, 8'h76);
    // R5: masked key bits
    p_kmask = 8'h0F;
    send("R5 key mask ignore", 8'hFF, 1'b0, 8'h7C);
    send("R5 key mask unmasked bit", 8'hFF, 1'b0, 8'hF7);
    // R6: inverted polarity
    p_kmask = 8'h00; p_kpol = 1'b1;
    send("R6 pol miss protect", 8'hFF, 1'b0, 8'h12);
    send("R6 pol hit write", 8'hFF, 1'b0, 8'h77);
    // R7: monochrome transparency
    clear_cfg(); p_fmt = 2'd2; p_fg = 8'hE1; p_bg = 8'h1E; p_mtr = 1'b1;
    send("R7 mono zero protect", 8'h00, 1'b0, 8'h99);
    send("R7 mono one write", 8'h00, 1'b1, 8'h99);
    p_mtr = 1'b0;
    send("R7 mono zero bg when off", 8'h00, 1'b0, 8'h99);
    // R8: write mask
    clear_cfg(); p_rop = 4'd15; p_wmask = 8'hF0;
    send("R8 wmask high nibble", 8'h00, 1'b0, 8'h35);
    p_rop = 4'd0; p_wmask = 8'h81;
    send("R8 wmask edge bits", 8'h00, 1'b0, 8'hFF);
    drain();

    // R10: back-to-back with no stall
    lat_mode = 1'b1;
    clear_cfg(); p_rop = 4'd6;
    for (int i = 0; i < 6; i++) send("R10 streaming", 8'(i * 37), 1'b0, 8'(i * 11));
    drain();
    lat_mode = 1'b0;

    // R9 and mixed: random pixels with random stalls
    for (int i = 0; i < 400; i++) begin
      p_rop = 4'($urandom); p_fmt = 2'($urandom);
      p_fg = 8'($urandom); p_bg = 8'($urandom);
      p_wmask = (($urandom % 3) == 0) ? 8'($urandom) : 8'hFF;
      p_ken = 1'($urandom); p_kpol = 1'($urandom); p_mtr = 1'($urandom);
      p_kmask = (($urandom % 2) == 0) ? 8'($urandom) : 8'h00;
      begin
        logic [7:0] d;
        d = 8'($urandom);
        p_key = (($urandom % 2) == 0) ? d : 8'($urandom);
        send("R9 random stream", 8'($urandom), 1'($urandom), d);
      end
    end
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule